// File: doc/BRIEF.md
# Single-Cycle Minimal RISC Core

This core completes one instruction per clock and writes all of that instruction's effects in a single state update: the program counter, one register and at most one data memory word. It holds eight 16-bit registers, an instruction memory and a separate data memory. The two memories have disjoint address spaces, so stores can never change the program.

Software loads the instruction memory through a preload port and then raises `run`. While `run` is low the core holds its state, and the preload port can write at any time. The only branch is a jump-if-zero that takes its target from a register. A separate instruction copies the program counter into a register, so code can find its own location and stay position independent. Two observation ports give the register file and the data memory to the environment.

Instruction word (16 bits): opcode in [15:13], destination register in [12:10], first source register A in [9:7], second source register B in [6:4], ALU function in [3:0]. Load-constant takes a 10-bit immediate from [9:0] and zero-extends it.

Top module: `sc_risc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and clears every register to 0.
- R2: While `run` is low and `rst` is low, the program counter, registers and data memory keep their values.
- R3: Opcode 0 (load constant) writes the zero-extended immediate [9:0] to the destination register, and the program counter advances by one.
- R4: Opcode 1 (load PC) writes the address of the executing instruction, zero-extended, to the destination register, and the program counter advances by one.
- R5: Opcode 2 (arithmetic) writes f(A, B) to the destination register in the same cycle, where f is selected by [3:0]: 0 add, 1 subtract (A minus B, modulo 2^16), 2 and, 3 or, 4 xor. The program counter advances by one.
- R6: Opcode 3 (jump if zero) with register A equal to zero loads the program counter from the low bits of register B.
- R7: Opcode 3 with register A non-zero advances the program counter by one.
- R8: Opcode 4 (load) writes the data memory word at the address held in register A to the destination register.
- R9: Opcode 5 (store) writes register B to the data memory word at the address held in register A. The instruction memory is never affected, even when that address equals an instruction address.
- R10: Opcodes 6 and 7 change nothing except advancing the program counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Execute one instruction on each clock while high |
| im_we | input | 1 | Instruction memory write strobe |
| im_addr | input | IM_AW | Instruction memory write address |
| im_wdata | input | 16 | Instruction word to write |
| dm_peek_addr | input | DM_AW | Data memory observation address |
| dm_peek_data | output | DW | Data memory word at dm_peek_addr |
| rf_sel | input | log2(NREG) | Register observation select |
| rf_data | output | DW | Value of the selected register |
| pc | output | IM_AW | Current program counter |

## Verification
The bench keeps its own model of the core and compares the program counter and all eight registers after every clock, so an update that lands one cycle late shows up at once. Subtraction is run with a result that wraps below zero. A core that swapped the operand order or truncated the result would leave a wrong value in the destination register.

The jump is exercised both taken and not taken. The instructions that a taken jump must skip would load a marker value, so executing them would show in the registers. The test program stores to data address 0, which is also the address of its first instruction, and then jumps back to address 0. A core that let the store reach the program would then execute a different instruction. Undefined opcodes sit in the path, and a core that wrote a register for them would fail the register comparison. Idle cycles and a second reset confirm that state holds while `run` is low and that reset clears it.

// File: rtl/sc_risc_core.sv
`timescale 1ns/1ps
module sc_risc_core #(
  parameter int DW    = 16,
  parameter int NREG  = 8,
  parameter int IM_AW = 8,
  parameter int DM_AW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run,
  input  logic                     im_we,
  input  logic [IM_AW-1:0]         im_addr,
  input  logic [15:0]              im_wdata,
  input  logic [DM_AW-1:0]         dm_peek_addr,
  output logic [DW-1:0]            dm_peek_data,
  input  logic [$clog2(NREG)-1:0]  rf_sel,
  output logic [DW-1:0]            rf_data,
  output logic [IM_AW-1:0]         pc
);
  localparam int RW    = $clog2(NREG);
  localparam int IMM_W = 10;
  localparam logic [2:0] OP_LDC  = 3'd0;
  localparam logic [2:0] OP_LDPC = 3'd1;
  localparam logic [2:0] OP_ALU  = 3'd2;
  localparam logic [2:0] OP_JZ   = 3'd3;
  localparam logic [2:0] OP_LD   = 3'd4;
  localparam logic [2:0] OP_ST   = 3'd5;

  logic [15:0]      imem [2**IM_AW];
  logic [DW-1:0]    dmem [2**DM_AW];
  logic [DW-1:0]    rf   [NREG];
  logic [IM_AW-1:0] pc_q;

  logic [15:0]   instr;
  logic [2:0]    op;
  logic [RW-1:0] rd, ra, rb;
  logic [3:0]    fn;
  logic [DW-1:0] src_a, src_b, alu_res, wb_val;
  logic          wb_en, exec;
  logic [IM_AW-1:0] pc_nxt;

  assign instr = imem[pc_q];
  assign op    = instr[15:13];
  assign rd    = instr[12 -: RW];
  assign ra    = instr[9 -: RW];
  assign rb    = instr[6 -: RW];
  assign fn    = instr[3:0];
  assign src_a = rf[ra];
  assign src_b = rf[rb];
  assign exec  = run && !rst;

  always_comb begin
    case (fn)
      4'd0:    alu_res = src_a + src_b;
      4'd1:    alu_res = src_a - src_b;
      4'd2:    alu_res = src_a & src_b;
      4'd3:    alu_res = src_a | src_b;
      4'd4:    alu_res = src_a ^ src_b;
      default: alu_res = '0;
    endcase
  end

  always_comb begin
    wb_en  = 1'b1;
    wb_val = '0;
    pc_nxt = pc_q + 1'b1;
    case (op)
      OP_LDC:  wb_val = {{(DW-IMM_W){1'b0}}, instr[IMM_W-1:0]};
      OP_LDPC: wb_val = {{(DW-IM_AW){1'b0}}, pc_q};
      OP_ALU:  wb_val = alu_res;
      OP_LD:   wb_val = dmem[src_a[DM_AW-1:0]];
      OP_JZ: begin
        wb_en = 1'b0;
        if (src_a == '0) pc_nxt = src_b[IM_AW-1:0];
      end
      default: wb_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (run) begin
      pc_q <= pc_nxt;
      if (wb_en) rf[rd] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (im_we) imem[im_addr] <= im_wdata;
  end

  always_ff @(posedge clk) begin
    if (exec && op == OP_ST) dmem[src_a[DM_AW-1:0]] <= src_b;
  end

  assign dm_peek_data = dmem[dm_peek_addr];
  assign rf_data      = rf[rf_sel];
  assign pc           = pc_q;
endmodule

// File: rtl/sc_risc_core_chk.sv
`timescale 1ns/1ps
module sc_risc_core_chk #(
  parameter int DW    = 16,
  parameter int IM_AW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic [2:0]       op,
  input logic [IM_AW-1:0] pc,
  input logic [DW-1:0]    src_a,
  input logic [IM_AW-1:0] jz_target
);
  logic [IM_AW-1:0] pc_inc;
  assign pc_inc = pc + 1'b1;

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == '0); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pc)); // R2
  AST_LDC_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && op == 3'd0) |=> pc == $past(pc_inc)); // R3
  AST_JZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (run && op == 3'd3 && src_a == '0) |=> pc == $past(jz_target)); // R6
  AST_JZ_FALL: assert property (@(posedge clk) disable iff (rst)
    (run && op == 3'd3 && src_a != '0) |=> pc == $past(pc_inc)); // R7
  AST_UNDEF_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && op[2:1] == 2'b11) |=> pc == $past(pc_inc)); // R10
endmodule

bind sc_risc_core sc_risc_core_chk #(.DW(DW), .IM_AW(IM_AW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .op(op), .pc(pc_q),
  .src_a(src_a), .jz_target(src_b[IM_AW-1:0])
);

// File: tb/sc_risc_core_tb.sv
`timescale 1ns/1ps
module sc_risc_core_tb;
  localparam int DW = 16, NR = 8, AW = 8, DAW = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, run = 1'b0, im_we = 1'b0;
  logic [AW-1:0]  im_addr = '0;
  logic [15:0]    im_wdata = '0;
  logic [DAW-1:0] dm_peek_addr = '0;
  logic [DW-1:0]  dm_peek_data, rf_data;
  logic [2:0]     rf_sel = '0;
  logic [AW-1:0]  pc;

  sc_risc_core #(.DW(DW), .NREG(NR), .IM_AW(AW), .DM_AW(DAW)) u_dut (
    .clk(clk), .rst(rst), .run(run), .im_we(im_we), .im_addr(im_addr),
    .im_wdata(im_wdata), .dm_peek_addr(dm_peek_addr), .dm_peek_data(dm_peek_data),
    .rf_sel(rf_sel), .rf_data(rf_data), .pc(pc));

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // reference model
  logic [15:0]   m_im [256];
  logic [DW-1:0] m_rf [NR];
  logic [DW-1:0] m_dm [256];
  logic [AW-1:0] m_pc;

  function automatic logic [15:0] e_ldc(int rd, int imm);
    return {3'd0, 3'(rd), 10'(imm)};
  endfunction
  function automatic logic [15:0] e_ldpc(int rd);
    return {3'd1, 3'(rd), 10'd0};
  endfunction
  function automatic logic [15:0] e_alu(int rd, int ra, int rb, int fn);
    return {3'd2, 3'(rd), 3'(ra), 3'(rb), 4'(fn)};
  endfunction
  function automatic logic [15:0] e_jz(int ra, int rb);
    return {3'd3, 3'd0, 3'(ra), 3'(rb), 4'd0};
  endfunction
  function automatic logic [15:0] e_ld(int rd, int ra);
    return {3'd4, 3'(rd), 3'(ra), 7'd0};
  endfunction
  function automatic logic [15:0] e_st(int ra, int rb);
    return {3'd5, 3'd0, 3'(ra), 3'(rb), 4'd0};
  endfunction

  task automatic m_reset();
    m_pc = '0;
    for (int i = 0; i < NR; i++) m_rf[i] = '0;
  endtask

  task automatic m_step(output string tag);
    logic [15:0] w;
    logic [DW-1:0] a, b;
    logic [AW-1:0] nxt;
    w = m_im[m_pc];
    a = m_rf[w[9:7]];
    b = m_rf[w[6:4]];
    nxt = m_pc + 1'b1;
    case (w[15:13])
      3'd0: begin m_rf[w[12:10]] = {6'd0, w[9:0]}; tag = "R3 load-constant"; end
      3'd1: begin m_rf[w[12:10]] = {8'd0, m_pc}; tag = "R4 load-pc"; end
      3'd2: begin
        case (w[3:0])
          4'd0: m_rf[w[12:10]] = a + b;
          4'd1: m_rf[w[12:10]] = a - b;
          4'd2: m_rf[w[12:10]] = a & b;
          4'd3: m_rf[w[12:10]] = a | b;
          4'd4: m_rf[w[12:10]] = a ^ b;
          default: m_rf[w[12:10]] = '0;
        endcase
        tag = "R5 arithmetic";
      end
      3'd3: begin
        if (a == '0) begin nxt = b[AW-1:0]; tag = "R6 jump taken"; end
        else tag = "R7 jump not taken";
      end
      3'd4: begin m_rf[w[12:10]] = m_dm[a[7:0]]; tag = "R8 load"; end
      3'd5: begin m_dm[a[7:0]] = b; tag = "R9 store"; end
      default: tag = "R10 undefined opcode";
    endcase
    m_pc = nxt;
  endtask

  // scoreboard
  typedef struct {
    logic [AW-1:0] pc;
    logic [DW-1:0] rf [NR];
    string         tag;
  } exp_t;
  exp_t q[$];

  task automatic push_exp(string tag);
    exp_t e;
    e.pc = m_pc;
    for (int i = 0; i < NR; i++) e.rf[i] = m_rf[i];
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(bit r);
    string tag;
    @(negedge clk);
    run = r;
    if (r) m_step(tag);
    else tag = "R2 idle hold";
    push_exp(tag);
  endtask

  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      #1;
      e = q.pop_front();
      check(e.tag, "pc", {8'd0, pc}, {8'd0, e.pc});
      for (int i = 0; i < NR; i++) begin
        rf_sel = 3'(i);
        #0.1;
        check(e.tag, $sformatf("r%0d", i), rf_data, e.rf[i]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin m_im[a] = {3'd6, 13'd0}; m_dm[a] = 'x; end
    m_im[0]  = e_ldc(1, 16'h3A5);
    m_im[1]  = e_ldc(2, 16'h0F0);
    m_im[2]  = e_alu(3, 1, 2, 0);
    m_im[3]  = e_alu(4, 2, 1, 1);   // wraps below zero
    m_im[4]  = e_alu(5, 1, 2, 2);
    m_im[5]  = e_alu(6, 1, 2, 3);
    m_im[6]  = e_alu(7, 1, 2, 4);
    m_im[7]  = e_st(2, 7);
    m_im[8]  = e_ld(3, 2);
    m_im[9]  = e_ldpc(4);
    m_im[10] = e_ldc(5, 0);
    m_im[11] = e_ldc(6, 17);
    m_im[12] = e_jz(1, 6);
    m_im[13] = {3'd6, 13'h1FFF};
    m_im[14] = e_jz(5, 6);
    m_im[15] = e_ldc(7, 16'h111);   // must be skipped
    m_im[16] = e_ldc(7, 16'h222);   // must be skipped
    m_im[17] = {3'd7, 13'h1555};
    m_im[18] = e_st(5, 1);          // data address 0 = instruction address 0
    m_im[19] = e_ldc(6, 0);
    m_im[20] = e_jz(6, 6);

    m_reset();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      im_we = 1'b1; im_addr = 8'(a); im_wdata = m_im[a];
    end
    @(negedge clk);
    im_we = 1'b0;
    rst = 1'b0;
    push_exp("R1 reset state");

    for (int c = 0; c < 60; c++) drive(1'b1);
    for (int c = 0; c < 4; c++) drive(1'b0);

    @(negedge clk);
    dm_peek_addr = 8'hF0; #0.1;
    check("R9 store word", "dm[F0]", dm_peek_data, m_dm[8'hF0]);
    dm_peek_addr = 8'h00; #0.1;
    check("R9 store to shared address", "dm[00]", dm_peek_data, m_dm[8'h00]);

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_reset();
    push_exp("R1 reset clears state");
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule